// File: doc/BRIEF.md
# Deglitched Latching Fault Reporter

This block sits beside a current-limited power switch and turns three raw
condition signals into one fault report. Excess current and reversed voltage
must each persist for a set number of slow timebase ticks before they count.
Excess temperature counts at once. A condition that has counted sets a latch.
The latch pulls the active-low fault line and asks the switch to turn off.

The latch ignores the conditions going away. It clears only when the enable
input is taken low, or when the chip is reset. A condition that is still
qualified when enable returns sets the latch again. The filters also hold off
release: a condition must stay absent for its full qualification time before
it stops counting.

A small status code records which source set the latch. The first source
wins. When two sources qualify together, temperature beats current, and
current beats voltage. The slow timebase comes from an internal clock divider.
All raw inputs and the enable cross into the clock domain through two-stage
synchronizers.

Top module: `fault_latch_reporter`

## Requirements
- R1: After reset, `flag_oe`, `latch_off` and `cause` are all 0.
- R2: The fault line is modelled by `flag_oe`. A value of 1 means the line is pulled low. A value of 0 means it is released. `flag_oe` goes to 1 only after some source has qualified.
- R3: With `en` high, a rise of `ot_raw` sets `flag_oe` on the third rising clock edge after the change, and not earlier.
- R4: Once `oc_raw` rises and stays high, `flag_oe` sets between (OC_TICKS-1)*TICK_DIV+4 and OC_TICKS*TICK_DIV+3 rising edges later.
- R5: Once `rv_raw` rises and stays high, `flag_oe` sets between (RV_TICKS-1)*TICK_DIV+4 and RV_TICKS*TICK_DIV+3 rising edges later.
- R6: A current or voltage pulse no longer than (N-1)*TICK_DIV clock cycles never sets the latch, where N is that source's tick count. A pulse of at least N*TICK_DIV cycles always sets it.
- R7: A current or voltage condition stays qualified after it drops. It releases only after it has been absent for its full tick count. An enable toggle made after release does not set the latch again.
- R8: While `en` stays high, the latch holds even after every raw condition has gone away.
- R9: A low on `en` clears `flag_oe`, `latch_off` and `cause` on the third rising edge. The latch stays clear for as long as `en` is low, whatever the inputs do.
- R10: If a source is still qualified when `en` returns high, the latch sets again on the third rising edge.
- R11: `cause` reports the source that set the latch: 01 for temperature, 10 for current, 11 for voltage. It stays fixed until the latch clears, even if other sources qualify later.
- R12: When several sources are qualified in the same cycle, temperature wins over current, and current wins over voltage.
- R13: `latch_off` equals `flag_oe` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Switch enable; a low clears the latch |
| ot_raw | input | 1 | Raw overtemperature condition |
| oc_raw | input | 1 | Raw overcurrent condition |
| rv_raw | input | 1 | Raw reverse-voltage condition |
| flag_oe | output | 1 | Pull-down enable for the active-low fault line |
| latch_off | output | 1 | Request to turn the power switch off |
| cause | output | 2 | Source that set the latch (00 means none) |

## Verification
The paths through the synchronizer alone have fixed latencies: a temperature
rise, an enable fall and an enable return each show on the outputs exactly
three rising edges later. The bench drives inputs and samples outputs at the
falling edge, and checks that these results are absent after two edges and
present after three. The filtered paths depend on where the prescaler stands,
so the bench sweeps every start phase and checks that the measured latency
falls inside the arithmetic window. It also sweeps every pulse width that
must be rejected. Exit filtering is observed by toggling enable while a
source is still held qualified, and again after the source has released.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int NSRC   = 3;
  localparam int SRC_OT = 0;
  localparam int SRC_OC = 1;
  localparam int SRC_RV = 2;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_OT   = 2'b01,
    CAUSE_OC   = 2'b10,
    CAUSE_RV   = 2'b11
  } cause_e;
endpackage

// File: rtl/fr_sync.sv
module fr_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/fr_prescaler.sv
module fr_prescaler #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/fr_deglitch.sv
module fr_deglitch #(
  parameter int TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic sig_i,
  output logic qual_o
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          qual_q, qual_d;

  always_comb begin
    cnt_d  = cnt_q;
    qual_d = qual_q;
    if (sig_i == qual_q) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        qual_d = sig_i;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      qual_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      qual_q <= qual_d;
    end
  end

  assign qual_o = qual_q;
endmodule

// File: rtl/fr_latch.sv
module fr_latch
  import fr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [NSRC-1:0] qual_i,
  output logic            latched_o,
  output cause_e          cause_o
);
  logic   set_q, set_d;
  cause_e cause_q, cause_d;

  always_comb begin
    set_d   = set_q;
    cause_d = cause_q;
    if (!en_i) begin
      set_d   = 1'b0;
      cause_d = CAUSE_NONE;
    end else if (!set_q && (|qual_i)) begin
      set_d = 1'b1;
      if (qual_i[SRC_OT])      cause_d = CAUSE_OT;
      else if (qual_i[SRC_OC]) cause_d = CAUSE_OC;
      else                     cause_d = CAUSE_RV;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      set_q   <= set_d;
      cause_q <= cause_d;
    end
  end

  assign latched_o = set_q;
  assign cause_o   = cause_q;
endmodule

// File: rtl/fault_latch_reporter.sv
module fault_latch_reporter
  import fr_pkg::*;
#(
  parameter int TICK_DIV = 1000,
  parameter int OC_TICKS = 8,
  parameter int RV_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       ot_raw,
  input  logic       oc_raw,
  input  logic       rv_raw,
  output logic       flag_oe,
  output logic       latch_off,
  output logic [1:0] cause
);
  localparam int SW     = NSRC + 1;
  localparam int EN_BIT = NSRC;

  logic [SW-1:0]   sync_w;
  logic [NSRC-1:0] qual_w;
  logic            tick_w;
  logic            latched_w;
  cause_e          cause_w;

  fr_sync #(.W(SW)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({en, rv_raw, oc_raw, ot_raw}),
    .q_o   (sync_w)
  );

  fr_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_w)
  );

  assign qual_w[SRC_OT] = sync_w[SRC_OT];

  for (genvar g = SRC_OC; g <= SRC_RV; g++) begin : g_filt
    localparam int T = (g == SRC_OC) ? OC_TICKS : RV_TICKS;
    fr_deglitch #(.TICKS(T)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_w),
      .sig_i  (sync_w[g]),
      .qual_o (qual_w[g])
    );
  end

  fr_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (sync_w[EN_BIT]),
    .qual_i    (qual_w),
    .latched_o (latched_w),
    .cause_o   (cause_w)
  );

  assign flag_oe   = latched_w;
  assign latch_off = latched_w;
  assign cause     = cause_w;
endmodule

// File: rtl/fr_checker.sv
module fr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       ot_raw,
  input logic       flag_oe,
  input logic [1:0] cause,
  input logic [2:0] qual,
  input logic       oc_sync
);
  logic [2:0] age_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 3'd4) age_q <= age_q + 1'b1;
  end
  assign warm = (age_q == 3'd4);

  p_ot_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
    warm && $past(ot_raw, 3) && $past(en, 3) |-> flag_oe);

  p_en_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    warm && !$past(en, 3) |-> !flag_oe);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    warm && $fell(flag_oe) |-> !$past(en, 3));

  p_rise_needs_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_oe) |-> $past(|qual));

  p_cause_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_oe |-> cause != 2'b00);

  p_cause_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_oe |-> cause == 2'b00);

  p_cause_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    warm && flag_oe && $past(flag_oe) |-> $stable(cause));

  p_oc_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual[1]) |-> $past(oc_sync));

  p_oc_leave_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(qual[1]) |-> !$past(oc_sync));
endmodule

bind fault_latch_reporter fr_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .ot_raw  (ot_raw),
  .flag_oe (flag_oe),
  .cause   (cause),
  .qual    (qual_w),
  .oc_sync (sync_w[1])
);

// File: tb/sim_fault_latch_reporter.sv
module sim_fault_latch_reporter;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 5;
  localparam int OCT  = 4;
  localparam int RVT  = 2;
  localparam int SETTLE = OCT * DIV + 10;

  logic clk, rst_n, en, ot_raw, oc_raw, rv_raw;
  logic flag_oe, latch_off;
  logic [1:0] cause;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  fault_latch_reporter #(.TICK_DIV(DIV), .OC_TICKS(OCT), .RV_TICKS(RVT)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .ot_raw(ot_raw), .oc_raw(oc_raw),
    .rv_raw(rv_raw), .flag_oe(flag_oe), .latch_off(latch_off), .cause(cause)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic state_chk(input string req, input int f, input int c);
    chk({req, " flag_oe"}, int'(flag_oe), f);
    chk({req, " latch_off (R13)"}, int'(latch_off), f);
    chk({req, " cause"}, int'(cause), c);
  endtask

  // drop all conditions, let the filters release, leave enable as requested
  task automatic settle(input bit en_after);
    ot_raw = 0; oc_raw = 0; rv_raw = 0; en = 0;
    wait_n(SETTLE);
    en = en_after;
    wait_n(4);
  endtask

  task automatic latency(input string req, input int src, input int t, input int cval);
    int n;
    n = 0;
    if (src == 1) oc_raw = 1; else rv_raw = 1;
    while (!flag_oe && n < 200) begin
      wait_n(1);
      n++;
    end
    vectors++;
    if (n < (t - 1) * DIV + 4 || n > t * DIV + 3) begin
      errors++;
      $display("FAIL %s latency actual=%0d expected=%0d..%0d", req, n,
               (t - 1) * DIV + 4, t * DIV + 3);
    end
    chk({req, " cause"}, int'(cause), cval);
  endtask

  initial begin
    rst_n = 0; en = 1; ot_raw = 0; oc_raw = 0; rv_raw = 0;
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    state_chk("R1 reset", 0, 0);

    // R3 / R2: overtemperature is unfiltered, third edge
    ot_raw = 1;
    wait_n(2);
    chk("R3 not before third edge", int'(flag_oe), 0);
    wait_n(1);
    state_chk("R3 R2 ot set", 1, 1);
    ot_raw = 0;
    wait_n(40);
    state_chk("R8 hold after fault gone", 1, 1);

    // R9: enable low clears on third edge and blocks latching
    en = 0;
    wait_n(2);
    chk("R9 not before third edge", int'(flag_oe), 1);
    wait_n(1);
    state_chk("R9 cleared", 0, 0);
    ot_raw = 1;
    wait_n(10);
    state_chk("R9 blocked while low", 0, 0);
    settle(1);

    // R4 / R5: latency windows over every prescaler phase
    for (int p = 0; p < DIV; p++) begin
      settle(1);
      wait_n(p);
      latency("R4 oc", 1, OCT, 2);
      settle(1);
      wait_n(p);
      latency("R5 rv", 2, RVT, 3);
    end

    // R6: pulse width sweep
    for (int s = 1; s <= 2; s++) begin
      int t;
      t = (s == 1) ? OCT : RVT;
      for (int w = 1; w <= (t - 1) * DIV; w++) begin
        settle(1);
        if (s == 1) oc_raw = 1; else rv_raw = 1;
        wait_n(w);
        oc_raw = 0; rv_raw = 0;
        wait_n(t * DIV + 10);
        chk("R6 short pulse rejected", int'(flag_oe), 0);
      end
      for (int w = t * DIV; w <= t * DIV + 3; w++) begin
        settle(1);
        if (s == 1) oc_raw = 1; else rv_raw = 1;
        wait_n(w);
        oc_raw = 0; rv_raw = 0;
        wait_n(6);
        chk("R6 long pulse accepted", int'(flag_oe), 1);
      end
    end

    // R10 / R7: exit filter observed through enable toggles
    settle(1);
    oc_raw = 1;
    wait_n(OCT * DIV + 5);
    chk("R4 oc latched", int'(flag_oe), 1);
    oc_raw = 0;
    en = 0;
    wait_n(4);
    state_chk("R9 toggle clears", 0, 0);
    en = 1;
    wait_n(2);
    chk("R10 not before third edge", int'(flag_oe), 0);
    wait_n(1);
    state_chk("R10 relatch while qualified", 1, 2);
    wait_n(SETTLE);
    en = 0;
    wait_n(4);
    en = 1;
    wait_n(6);
    state_chk("R7 released after full time", 0, 0);

    // R12: simultaneous qualification priority
    settle(0);
    oc_raw = 1; rv_raw = 1;
    wait_n(SETTLE);
    chk("R9 no latch while low", int'(flag_oe), 0);
    en = 1;
    wait_n(4);
    state_chk("R12 oc over rv", 1, 2);
    en = 0;
    ot_raw = 1;
    wait_n(4);
    en = 1;
    wait_n(4);
    state_chk("R12 ot over oc", 1, 1);

    // R11: first source wins
    settle(1);
    rv_raw = 1;
    wait_n(RVT * DIV + 5);
    state_chk("R11 rv first", 1, 3);
    ot_raw = 1;
    wait_n(5);
    oc_raw = 1;
    wait_n(SETTLE);
    state_chk("R11 cause frozen", 1, 3);
    settle(1);
    state_chk("R1 quiet after settle", 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule